// File: doc/BRIEF.md
# Two-Wire Bus Line Conditioner

This block sits between the two raw lines of a two-wire serial bus (a clock line and a bidirectional data line) and the protocol engine that decodes bytes. Both lines arrive with no timing relation to the system clock. Each line passes through a synchronizer chain and then a glitch filter. The filter discards any pulse shorter than a noise-suppression window that is counted in system clocks. The filtered levels are then turned into single-cycle strobes. The strobes mark the clock line rising (the data sampling point) and the clock line falling (the point where the data line may change). They also mark the two bus conditions: a start, which is the data line falling while the clock line is high, and a stop, which is the data line rising while the clock line is high.

Two window lengths are available, a short one and a long one, and an input pin selects between them. This covers a fast supply mode and a slow supply mode. Apart from a flag that shows whether a transfer is in progress between a start and a stop, the block holds no protocol state.

Top module: `twi_line_conditioner`

## Requirements
- R1: During and right after a synchronous reset, sda_lvl_o is 1, busy_o is 0 and all four strobes are 0.
- R2: After a raw level change is first sampled, and with that level held steady, sda_lvl_o shows the new level after exactly N+3 rising clock edges. N is the active window length.
- R3: A raw pulse held for fewer than N consecutive samples never changes the filtered level and never produces any strobe.
- R4: When win_long_i is 1, N equals LONG_CYCLES. When it is 0, N equals SHORT_CYCLES.
- R5: start_o pulses for one clock when the filtered data line falls while the filtered clock line is high in both the current and the previous cycle.
- R6: stop_o pulses for one clock when the filtered data line rises while the filtered clock line is high in both the current and the previous cycle.
- R7: scl_rise_o pulses for exactly one clock on each filtered low-to-high change of the clock line.
- R8: scl_fall_o pulses for exactly one clock on each filtered high-to-low change of the clock line.
- R9: A data line change while the clock line is low produces neither start_o nor stop_o.
- R10: busy_o becomes 1 in the same cycle as a start_o pulse and becomes 0 in the same cycle as a stop_o pulse. Otherwise it holds its value.
- R11: start_o and stop_o are never 1 in the same cycle, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| win_long_i | input | 1 | 1 selects the long suppression window, 0 selects the short one |
| scl_raw_i | input | 1 | Asynchronous raw clock line |
| sda_raw_i | input | 1 | Asynchronous raw data line |
| sda_lvl_o | output | 1 | Filtered, registered data line level |
| start_o | output | 1 | One-cycle start condition strobe |
| stop_o | output | 1 | One-cycle stop condition strobe |
| scl_rise_o | output | 1 | One-cycle strobe on a filtered clock rise |
| scl_fall_o | output | 1 | One-cycle strobe on a filtered clock fall |
| busy_o | output | 1 | Transfer in progress, from start to stop |

## Verification
The bench builds the block with SHORT_CYCLES=4 and LONG_CYCLES=9. With these values a three-sample spike sits just under the short window, and an eight-sample spike passes the short window but is rejected by the long one. Both sides of each filter threshold are therefore reached in a few hundred cycles. The same values make the N+3 latency differ between the two modes, so a wrong window choice shows up as a timing mismatch as well as a missed strobe.

// File: rtl/twi_cond_pkg.sv
package twi_cond_pkg;
  // bit 1 carries the clock line, bit 0 carries the data line
  typedef struct packed {
    logic scl;
    logic sda;
  } twi_lines_t;

  localparam int unsigned TWI_LINES = 2;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
  parameter int unsigned SHORT_CYCLES = 5,
  parameter int unsigned LONG_CYCLES  = 10,
  parameter int unsigned CNT_W        = $clog2(LONG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic win_long_i,
  input  logic d_i,
  output logic q_o
);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_CYCLES - 1);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_CYCLES - 1);

  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] limit;

  assign limit = win_long_i ? LONG_LIM : SHORT_LIM;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o     <= 1'b1;
      run_cnt <= '0;
    end else if (d_i == q_o) begin
      run_cnt <= '0;
    end else if (run_cnt >= limit) begin
      q_o     <= d_i;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/twi_event_detect.sv
module twi_event_detect
  import twi_cond_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  twi_lines_t lines_i,
  output logic       sda_lvl_o,
  output logic       start_o,
  output logic       stop_o,
  output logic       scl_rise_o,
  output logic       scl_fall_o,
  output logic       busy_o
);
  twi_lines_t prev;
  logic scl_held, start_c, stop_c;

  assign scl_held = prev.scl & lines_i.scl;
  assign start_c  = scl_held & prev.sda & ~lines_i.sda;
  assign stop_c   = scl_held & ~prev.sda & lines_i.sda;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev       <= '1;
      sda_lvl_o  <= 1'b1;
      start_o    <= 1'b0;
      stop_o     <= 1'b0;
      scl_rise_o <= 1'b0;
      scl_fall_o <= 1'b0;
      busy_o     <= 1'b0;
    end else begin
      prev       <= lines_i;
      sda_lvl_o  <= lines_i.sda;
      start_o    <= start_c;
      stop_o     <= stop_c;
      scl_rise_o <= ~prev.scl & lines_i.scl;
      scl_fall_o <= prev.scl & ~lines_i.scl;
      if (start_c)     busy_o <= 1'b1;
      else if (stop_c) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/twi_line_conditioner.sv
module twi_line_conditioner
  import twi_cond_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned SHORT_CYCLES = 5,
  parameter int unsigned LONG_CYCLES  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic win_long_i,
  input  logic scl_raw_i,
  input  logic sda_raw_i,
  output logic sda_lvl_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(LONG_CYCLES + 1);

  logic [TWI_LINES-1:0] raw_vec, sync_vec, filt_vec;
  twi_lines_t filt_lines;

  assign raw_vec = {scl_raw_i, sda_raw_i};

  twi_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (TWI_LINES),
    .RST_VAL('1)
  ) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_vec), .q_o(sync_vec)
  );

  for (genvar l = 0; l < TWI_LINES; l++) begin : g_filt
    twi_glitch_filter #(
      .SHORT_CYCLES(SHORT_CYCLES),
      .LONG_CYCLES (LONG_CYCLES),
      .CNT_W       (CNT_W)
    ) u_filt (
      .clk(clk), .rst(rst), .win_long_i(win_long_i),
      .d_i(sync_vec[l]), .q_o(filt_vec[l])
    );
  end

  assign filt_lines = twi_lines_t'(filt_vec);

  twi_event_detect u_evt (
    .clk(clk), .rst(rst), .lines_i(filt_lines),
    .sda_lvl_o(sda_lvl_o), .start_o(start_o), .stop_o(stop_o),
    .scl_rise_o(scl_rise_o), .scl_fall_o(scl_fall_o), .busy_o(busy_o)
  );
endmodule

// File: rtl/twi_line_conditioner_chk.sv
module twi_line_conditioner_chk (
  input logic clk,
  input logic rst,
  input logic win_long_i,
  input logic scl_raw_i,
  input logic sda_raw_i,
  input logic sda_lvl_o,
  input logic start_o,
  input logic stop_o,
  input logic scl_rise_o,
  input logic scl_fall_o,
  input logic busy_o
);
  // R11
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (rst) !(start_o && stop_o));
  // R11
  start_single_chk: assert property (@(posedge clk) disable iff (rst) start_o |=> !start_o);
  // R11
  stop_single_chk: assert property (@(posedge clk) disable iff (rst) stop_o |=> !stop_o);
  // R5
  start_sda_fell_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (!sda_lvl_o && $past(sda_lvl_o)));
  // R6
  stop_sda_rose_chk: assert property (@(posedge clk) disable iff (rst)
    stop_o |-> (sda_lvl_o && !$past(sda_lvl_o)));
  // R7
  rise_single_chk: assert property (@(posedge clk) disable iff (rst) scl_rise_o |=> !scl_rise_o);
  // R8
  fall_single_chk: assert property (@(posedge clk) disable iff (rst) scl_fall_o |=> !scl_fall_o);
  // R7
  rise_fall_excl_chk: assert property (@(posedge clk) disable iff (rst) !(scl_rise_o && scl_fall_o));
  // R10
  busy_set_chk: assert property (@(posedge clk) disable iff (rst) start_o |-> busy_o);
  // R10
  busy_clr_chk: assert property (@(posedge clk) disable iff (rst) stop_o |-> !busy_o);
  // R10
  busy_rise_cause_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy_o) |-> start_o);
  // R10
  busy_fall_cause_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy_o) |-> stop_o);
endmodule

bind twi_line_conditioner twi_line_conditioner_chk u_chk (.*);

// File: tb/twi_line_conditioner_bench.sv
module twi_line_conditioner_bench;
  localparam int SHORT = 4;
  localparam int LONG  = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic win = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic sda_lvl, start, stop, srise, sfall, busy;

  int checks = 0;
  int errors = 0;
  int n_start = 0, n_stop = 0, n_rise = 0, n_fall = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  twi_line_conditioner #(.SYNC_STAGES(2), .SHORT_CYCLES(SHORT), .LONG_CYCLES(LONG)) u_twi_line_conditioner (
    .clk(clk), .rst(rst), .win_long_i(win), .scl_raw_i(scl), .sda_raw_i(sda),
    .sda_lvl_o(sda_lvl), .start_o(start), .stop_o(stop),
    .scl_rise_o(srise), .scl_fall_o(sfall), .busy_o(busy));

  // behavioural reference: index 0 = data line, 1 = clock line
  bit q_hist[2][$];
  bit m_f[2], m_pf[2];
  int m_run[2];
  bit e_lvl = 1'b1, e_start, e_stop, e_rise, e_fall, e_busy;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0b expected %0b", req, cyc, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        q_hist[i] = '{1'b1, 1'b1};
        m_f[i] = 1'b1; m_pf[i] = 1'b1; m_run[i] = 0;
      end
      e_lvl = 1'b1; e_start = 0; e_stop = 0; e_rise = 0; e_fall = 0; e_busy = 0;
    end else begin
      int win_n;
      bit seen;
      win_n = win ? LONG : SHORT;
      // events from current filtered vs previous filtered
      e_start = m_f[1] && m_pf[1] && m_pf[0] && !m_f[0];
      e_stop  = m_f[1] && m_pf[1] && !m_pf[0] && m_f[0];
      e_rise  = m_f[1] && !m_pf[1];
      e_fall  = !m_f[1] && m_pf[1];
      e_lvl   = m_f[0];
      if (e_start) e_busy = 1;
      else if (e_stop) e_busy = 0;
      for (int i = 0; i < 2; i++) begin
        m_pf[i] = m_f[i];
        seen = q_hist[i][0];
        if (seen != m_f[i]) begin
          m_run[i] = m_run[i] + 1;
          if (m_run[i] >= win_n) begin m_f[i] = seen; m_run[i] = 0; end
        end else m_run[i] = 0;
        void'(q_hist[i].pop_front());
        q_hist[i].push_back(i == 0 ? sda : scl);
      end
    end
  end

  // compare on the falling edge, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R2 sda level", sda_lvl, e_lvl);
      chk("R5 start", start, e_start);
      chk("R6 stop", stop, e_stop);
      chk("R7 scl rise", srise, e_rise);
      chk("R8 scl fall", sfall, e_fall);
      chk("R10 busy", busy, e_busy);
      if (!rst) begin
        n_start += start; n_stop += stop; n_rise += srise; n_fall += sfall;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int k;
    int s0;
    wait_cyc(4);
    // R1 reset state
    chk("R1 level", sda_lvl, 1'b1);
    chk("R1 start", start, 1'b0);
    chk("R1 busy", busy, 1'b0);
    rst = 1'b0;
    wait_cyc(20);
    chk_int("R1 no strobes after reset", n_start + n_stop + n_rise + n_fall, 0);

    // R5 R10: start condition, short window
    sda = 0; wait_cyc(20);
    chk_int("R5 one start", n_start, 1);
    chk("R10 busy after start", busy, 1'b1);

    // R8 clock falls
    scl = 0; wait_cyc(20);
    chk_int("R8 one fall", n_fall, 1);

    // R2 latency: change data while clock low, count edges
    sda = 1; k = 0;
    while (sda_lvl !== 1'b1 && k < 50) begin @(negedge clk); k++; end
    chk_int("R2 latency short window", k, SHORT + 3);
    // R9 more data toggles while clock low
    sda = 0; wait_cyc(15); sda = 1; wait_cyc(15);
    chk_int("R9 no start while scl low", n_start, 1);
    chk_int("R9 no stop while scl low", n_stop, 0);

    // R7 clock pulses
    for (int b = 0; b < 3; b++) begin
      scl = 1; wait_cyc(12); scl = 0; wait_cyc(12);
    end
    chk_int("R7 rises", n_rise, 3);
    chk_int("R8 falls", n_fall, 4);

    // R6 stop: clock high, data low->high
    sda = 0; wait_cyc(12); scl = 1; wait_cyc(12); sda = 1; wait_cyc(15);
    chk_int("R6 one stop", n_stop, 1);
    chk("R10 busy after stop", busy, 1'b0);

    // R3 spike just under short window while clock high
    s0 = n_start;
    sda = 0; wait_cyc(SHORT - 1); sda = 1; wait_cyc(20);
    chk_int("R3 short spike ignored", n_start, s0);
    chk("R3 level unchanged", sda_lvl, 1'b1);
    chk("R3 busy unchanged", busy, 1'b0);

    // R4 long window rejects an 8-sample spike
    win = 1; wait_cyc(5);
    sda = 0; wait_cyc(LONG - 1); sda = 1; wait_cyc(25);
    chk_int("R4 long window rejects", n_start, s0);
    // R4 same spike in short window passes
    win = 0; wait_cyc(5);
    sda = 0; wait_cyc(LONG - 1); sda = 1; wait_cyc(25);
    chk_int("R4 short window passes start", n_start, s0 + 1);
    chk_int("R4 short window passes stop", n_stop, 2);

    // R2 latency long window
    win = 1; wait_cyc(5);
    scl = 0; wait_cyc(20);
    sda = 0; k = 0;
    while (sda_lvl !== 1'b0 && k < 50) begin @(negedge clk); k++; end
    chk_int("R2 latency long window", k, LONG + 3);
    // R3 clock spike under long window produces no edge
    s0 = n_rise;
    scl = 1; wait_cyc(LONG - 1); scl = 0; wait_cyc(25);
    chk_int("R3 clock spike ignored", n_rise, s0);

    wait_cyc(5);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule